// File: doc/BRIEF.md
# Software-Break Bus Cycle Sequencer

This block drives the bus while an 8-bit processor core executes its software-break instruction. The core's decoder pulses `start_i` in the decode cycle. In that cycle the block captures the current program counter, status byte, stack pointer and order mode. It then runs six bus cycles:

- three pushes onto a descending stack in page 0x01;
- two reads of a 16-bit vector from the top two addresses of the map;
- an opcode fetch from the vector address, which is flagged by `done_o`.

The mode input chooses between two cycle orders.

- **Classic order** issues the three stack writes back to back.
- **Interleaved order** puts a vector read after each of the first two pushes. This means the write strobe always drops for one cycle between writes, which suits asynchronous memories that need a strobe edge per write.

Both orders take the same number of cycles. One adder forms the vector addresses and the decremented stack pointer.

Top module: `brk_seq`

## Requirements
- R1: After reset, and whenever no sequence is in progress, `we_o` is 0, `done_o` is 0, `addr_o` is 0x0000 and `wdata_o` is 0x00.
- R2: `start_i` is accepted only when the block is idle. A pulse during a running sequence does not change the sequence, and neither do changes on `mode_i`, `pc_i`, `status_i` or `sp_i` in that time.
- R3: With `mode_i`=0 (classic), the six cycles after the start cycle are, in this order: write PC[15:8], write PC[7:0], write status, read 0xFFFE, read 0xFFFF, fetch.
- R4: With `mode_i`=1 (interleaved), the six cycles after the start cycle are, in this order: write PC[15:8], read 0xFFFE, write PC[7:0], read 0xFFFF, write status, fetch.
- R5: In interleaved order, `we_o` is never high on two consecutive cycles.
- R6: Each write goes to address {0x01, SP}, where SP is the stack pointer before that write. SP decrements by one after each write and wraps from 0x00 to 0xFF. `sp_o` shows the working SP.
- R7: Read cycles drive `addr_o` to 0xFFFE and then 0xFFFF with `we_o`=0. The fetch address is {byte read at 0xFFFF, byte read at 0xFFFE}.
- R8: `done_o` is high for exactly one cycle, the fetch cycle, which is the sixth cycle after the start cycle. `we_o` is 0 in that cycle.
- R9: The whole instruction, start cycle included, takes 7 cycles in either mode. The block is idle again on the following cycle and can accept a new start there.
- R10: After a sequence, `sp_o` equals the captured SP minus 3, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Decode-cycle pulse that begins the sequence |
| mode_i | input | 1 | 0 = classic order, 1 = interleaved order |
| pc_i | input | 16 | Program counter to save |
| status_i | input | 8 | Status byte to save |
| sp_i | input | 8 | Stack pointer at start |
| data_i | input | 8 | Read data, valid in the cycle its address is driven |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data |
| we_o | output | 1 | Write strobe |
| sp_o | output | 8 | Working stack pointer |
| done_o | output | 1 | High on the opcode fetch cycle |

## Verification
Inputs are captured on the edge that ends the start cycle. Bus cycle k (1 to 6) is therefore visible on the outputs during the k-th cycle after that edge. The bench samples on every falling edge, so each cycle is checked once, half a period after its registers settle.

Each vector byte is captured on the edge that ends its read cycle. It is first seen on the fetch address. The decremented SP appears on `sp_o` one cycle after each write. The final `sp_o` and the idle state are checked in the seventh cycle after the start edge.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PUSH_PCH, OP_PUSH_PCL, OP_PUSH_ST, OP_VEC_LO, OP_VEC_HI, OP_FETCH
  } bus_op_e;

  localparam int unsigned STEP_W    = 3;
  localparam int unsigned LAST_STEP = 6;

  // step 1..6 -> bus op; interleave places vector reads between pushes
  function automatic bus_op_e op_for_step(input logic interleave, input logic [STEP_W-1:0] step);
    bus_op_e op;
    case (step)
      3'd1:    op = OP_PUSH_PCH;
      3'd2:    op = interleave ? OP_VEC_LO : OP_PUSH_PCL;
      3'd3:    op = interleave ? OP_PUSH_PCL : OP_PUSH_ST;
      3'd4:    op = interleave ? OP_VEC_HI : OP_VEC_LO;
      3'd5:    op = interleave ? OP_PUSH_ST : OP_VEC_HI;
      3'd6:    op = OP_FETCH;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

  function automatic logic is_push(input bus_op_e op);
    return (op == OP_PUSH_PCH) || (op == OP_PUSH_PCL) || (op == OP_PUSH_ST);
  endfunction
endpackage

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl
  import brk_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    mode_i,
  output logic    accept_o,
  output bus_op_e op_o
);
  logic [STEP_W-1:0] step_q;
  logic              mode_q;

  assign accept_o = start_i && (step_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      mode_q <= 1'b0;
    end else if (accept_o) begin
      step_q <= STEP_W'(1);
      mode_q <= mode_i;
    end else if (step_q == STEP_W'(LAST_STEP)) begin
      step_q <= '0;
    end else if (step_q != '0) begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  always_comb begin
    if (step_q == '0) op_o = OP_IDLE;
    else              op_o = op_for_step(mode_q, step_q);
  end

  // R2: sequence enters step 1 only from idle
  assert_restart_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == STEP_W'(1)) |-> ($past(step_q) == '0));

  // R5: interleaved order never writes twice in a row
  assert_no_back_to_back_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && is_push(op_o)) |=> !is_push(op_o));

  // R8: fetch cycle lasts one cycle
  assert_single_fetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_FETCH) |=> (op_o != OP_FETCH));
endmodule

// File: rtl/brk_seq_dp.sv
module brk_seq_dp
  import brk_seq_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 2 * DW,
  parameter logic [AW-1:0] VEC_BASE = '1 - AW'(1),
  parameter logic [AW-DW-1:0] STACK_PAGE = (AW-DW)'(1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  bus_op_e       op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic [DW-1:0] sp_o,
  output logic          done_o
);
  logic [AW-1:0] pc_q;
  logic [DW-1:0] st_q, sp_q, vlo_q, vhi_q;
  logic [AW-1:0] add_a, add_b, add_sum;
  logic          push;

  assign push = is_push(op_i);

  // single adder: stack decrement, vector address offset, fetch address pass
  always_comb begin
    add_a = '0;
    add_b = '0;
    unique case (op_i)
      OP_PUSH_PCH, OP_PUSH_PCL, OP_PUSH_ST: begin
        add_a = {STACK_PAGE, sp_q};
        add_b = '1;
      end
      OP_VEC_LO: add_a = VEC_BASE;
      OP_VEC_HI: begin
        add_a = VEC_BASE;
        add_b = AW'(1);
      end
      OP_FETCH:  add_a = {vhi_q, vlo_q};
      default: ;
    endcase
  end
  assign add_sum = add_a + add_b;

  always_comb begin
    addr_o  = push ? {STACK_PAGE, sp_q} : add_sum;
    we_o    = push;
    done_o  = (op_i == OP_FETCH);
    unique case (op_i)
      OP_PUSH_PCH: wdata_o = pc_q[AW-1:AW-DW];
      OP_PUSH_PCL: wdata_o = pc_q[DW-1:0];
      OP_PUSH_ST:  wdata_o = st_q;
      default:     wdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      st_q  <= '0;
      sp_q  <= '0;
      vlo_q <= '0;
      vhi_q <= '0;
    end else begin
      if (accept_i) begin
        pc_q <= pc_i;
        st_q <= status_i;
        sp_q <= sp_i;
      end
      if (push)               sp_q  <= add_sum[DW-1:0];
      if (op_i == OP_VEC_LO)  vlo_q <= data_i;
      if (op_i == OP_VEC_HI)  vhi_q <= data_i;
    end
  end

  assign sp_o = sp_q;

  // R6: every write is followed by a one-step SP decrement
  assert_sp_dec_after_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (sp_o == DW'($past(sp_o) - DW'(1))));

  // R6: writes land in the stack page
  assert_wr_in_stack_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (addr_o[AW-1:DW] == STACK_PAGE));

  // R7: high vector read sits one above the base
  assert_vec_hi_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_VEC_HI) |-> (addr_o == VEC_BASE + AW'(1)) && !we_o);

  // R8: fetch never writes
  assert_fetch_no_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !we_o);
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic [DW-1:0] sp_o,
  output logic          done_o
);
  logic    accept;
  bus_op_e op;

  brk_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .accept_o (accept),
    .op_o     (op)
  );

  brk_seq_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .op_i     (op),
    .pc_i     (pc_i),
    .status_i (status_i),
    .sp_i     (sp_i),
    .data_i   (data_i),
    .addr_o   (addr_o),
    .wdata_o  (wdata_o),
    .we_o     (we_o),
    .sp_o     (sp_o),
    .done_o   (done_o)
  );

  // R1: idle bus is quiet
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_IDLE) |-> (!we_o && !done_o && addr_o == '0));
endmodule

// File: tb/brk_seq_tb_top.sv
module brk_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  status_i = '0;
  logic [7:0]  sp_i = '0;
  logic [7:0]  data_i;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o;
  logic        we_o;
  logic [7:0]  sp_o;
  logic        done_o;

  logic [7:0]  mem_vlo = '0, mem_vhi = '0;
  int unsigned n_checks = 0, n_errors = 0;
  bit          finished = 0;

  always #4ns clk_i = ~clk_i;

  // memory model: vector bytes at top, filler elsewhere
  always_comb begin
    if (addr_o == 16'hFFFE)      data_i = mem_vlo;
    else if (addr_o == 16'hFFFF) data_i = mem_vhi;
    else                         data_i = addr_o[7:0] ^ 8'hA5;
  end

  brk_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .pc_i(pc_i), .status_i(status_i), .sp_i(sp_i), .data_i(data_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .we_o(we_o), .sp_o(sp_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // op codes: 1 PCH, 2 PCL, 3 ST, 4 VLO, 5 VHI, 6 FETCH
  function automatic int exp_op(input bit inter, input int k);
    int cl[6] = '{1, 2, 3, 4, 5, 6};
    int il[6] = '{1, 4, 2, 5, 3, 6};
    return inter ? il[k-1] : cl[k-1];
  endfunction

  task automatic run_brk(input bit m, input logic [15:0] pc, input logic [7:0] st,
                         input logic [7:0] sp, input logic [7:0] vlo, input logic [7:0] vhi,
                         input bit disturb);
    logic [7:0] esp = sp;
    logic [15:0] ea;
    logic [7:0] ed;
    bit prev_we = 0;
    string rq = m ? "R4" : "R3";
    mem_vlo = vlo; mem_vhi = vhi;
    mode_i = m; pc_i = pc; status_i = st; sp_i = sp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      int op = exp_op(m, k);
      ed = 8'h00;
      case (op)
        1: begin ea = {8'h01, esp}; ed = pc[15:8]; end
        2: begin ea = {8'h01, esp}; ed = pc[7:0]; end
        3: begin ea = {8'h01, esp}; ed = st; end
        4: ea = 16'hFFFE;
        5: ea = 16'hFFFF;
        default: ea = {vhi, vlo};
      endcase
      check(op <= 3 ? "R6" : (op == 6 ? "R7" : rq), "addr", addr_o, ea);
      check(rq, "we", we_o, op <= 3);
      check(rq, "wdata", wdata_o, ed);
      check("R8", "done", done_o, op == 6);
      if (op <= 3) check("R6", "sp_o", sp_o, esp);
      if (m) check("R5", "no consecutive we", prev_we && we_o, 0);
      prev_we = we_o;
      if (op <= 3) esp = esp - 8'd1;
      if (disturb && k == 2) begin
        start_i = 1'b1; mode_i = ~m; pc_i = ~pc; status_i = ~st; sp_i = sp + 8'd77;
      end
      if (disturb && k == 3) start_i = 1'b0;
      @(negedge clk_i);
    end
    check("R9", "idle after 7 cycles: done", done_o, 0);
    check("R9", "idle after 7 cycles: we", we_o, 0);
    check("R1", "idle addr", addr_o, 16'h0000);
    check("R10", "final sp", sp_o, 8'(sp - 8'd3));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    @(negedge clk_i);
    check("R1", "reset we", we_o, 0);
    check("R1", "reset done", done_o, 0);
    check("R1", "reset addr", addr_o, 0);
    check("R1", "reset wdata", wdata_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "idle after reset", {we_o, done_o}, 0);
    // directed corners: SP wrap in both modes, disturbance during run
    run_brk(1'b0, 16'h1234, 8'h30, 8'h01, 8'h00, 8'hC0, 1'b0);
    run_brk(1'b1, 16'hABCD, 8'hF3, 8'h00, 8'h34, 8'h12, 1'b0);
    run_brk(1'b0, 16'h8001, 8'h24, 8'hFF, 8'hFF, 8'hFF, 1'b1);
    run_brk(1'b1, 16'hFFFF, 8'h00, 8'h02, 8'h55, 8'hAA, 1'b1);
    // start on the idle cycle right after a sequence (R9)
    for (int i = 0; i < 40; i++) begin
      run_brk(1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule